// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block keeps one private write-back cache coherent with its peers on a shared snooping bus. It holds a coherence state (invalid, shared or exclusive-dirty) and a tag for every set of a small direct-mapped tag array. It accepts read, write and evict requests from its own processor. It issues bus reads, bus invalidating writes and write-backs through a request/grant port, and it watches the transactions that other caches put on the same bus.

The bus is a single broadcast medium. A granted transaction is seen by every other controller in the same cycle, so all controllers observe one global order. The controller does not hold the data array. It reports coherence decisions at its ports: completion, the bus commands it issues, and a snoop flush. A flush means that its dirty copy must be written to memory before the snooped transaction is served.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every set is invalid, so the first read of any address issues a bus read, and no completion, bus request or flush is active during reset.
- R2: A read that misses issues a bus read (bus_cmd 2'b01) and fills the set in shared state. A read that hits completes without any bus transaction.
- R3: A write to a line that is not held exclusive issues an invalidating bus write (bus_cmd 2'b10) and moves the line to exclusive. Every other controller holding that line goes invalid, so its next read of it misses and issues a bus read.
- R4: A write to a line held exclusive completes locally, with no bus transaction, in the cycle after it is accepted.
- R5: A snooped bus read that matches an exclusive line raises snp_flush in that same cycle and downgrades the line to shared, so a later local write needs a new bus write.
- R6: Replacing an exclusive line first issues a write-back (bus_cmd 2'b11) of the old address. This applies both to a conflicting read or write to the same set and to an evict request (cpu_op 2'b10). Evicting a shared line is silent.
- R7: snp_flush is raised only for a valid snooped bus read or bus write that matches an exclusive line. A shared holder never flushes, and a snooped write-back changes nothing.
- R8: A snoop to the set of the pending local request takes priority. The local decision is retried in a later cycle from the updated state, and a bus request already raised is withdrawn in the cycle after such a snoop.
- R9: cpu_done is a one-cycle pulse. It follows a granted bus read or bus write by one cycle and never directly follows a granted write-back. The processor encodes requests as cpu_op 2'b00 read, 2'b01 write and 2'b10 evict.
- R10: With two controllers sharing the bus, no read ever returns a value older than the latest completed write to that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_done |
| cpu_op | input | 2 | Request kind: 00 read, 01 write, 10 evict |
| cpu_addr | input | ADDR_W | Request line address, {tag, set index} |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request, held until granted or withdrawn |
| bus_cmd | output | 2 | 01 bus read, 10 bus write, 11 write-back, 00 when idle |
| bus_addr | output | ADDR_W | Line address of the requested transaction |
| bus_gnt | input | 1 | Grant; the transaction occurs in this cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | ADDR_W | Line address of the snooped transaction |
| snp_flush | output | 1 | Dirty copy must be written back for this snoop |

## Verification
The bench builds two controllers with ADDR_W=6 and SETS=4. Requests are confined to two sets and three tags per set, so conflict evictions, write-backs of dirty victims, and both controllers contending for the same line happen within a handful of requests. A data model sits behind the bus and memory, driven only by the observed commands and flushes. It shows a missing invalidation or flush as a stale read, and directed steps force a same-cycle contention that makes the losing controller withdraw and retry.

// File: rtl/coh_pkg.sv
// Shared encodings for the snooping coherence controller.
// Assumes a {tag, index} line address and a single broadcast bus.
package coh_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_SHR = 2'b01,
        LN_EXC = 2'b10
    } line_st_t;

    typedef enum logic [1:0] {
        OP_RD = 2'b00,
        OP_WR = 2'b01,
        OP_EV = 2'b10
    } cpu_op_t;

    typedef enum logic [1:0] {
        BUS_NONE = 2'b00,
        BUS_RD   = 2'b01,
        BUS_INV  = 2'b10,
        BUS_WB   = 2'b11
    } bus_cmd_t;

endpackage

// File: rtl/coh_tag_array.sv
// Per-set coherence state and tag storage.
// Two combinational read ports (local, snoop) and two write ports.
// The snoop write port wins when both target the same set.
// Assumes SETS is a power of two.
module coh_tag_array
    import coh_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output line_st_t         ra_st,
    output logic [TAG_W-1:0] ra_tag,
    input  logic [IDX_W-1:0] rb_idx,
    output line_st_t         rb_st,
    output logic [TAG_W-1:0] rb_tag,
    input  logic             ws_en,
    input  logic [IDX_W-1:0] ws_idx,
    input  line_st_t         ws_st,
    input  logic             wl_en,
    input  logic [IDX_W-1:0] wl_idx,
    input  line_st_t         wl_st,
    input  logic [TAG_W-1:0] wl_tag
);

    line_st_t         st_q  [SETS];
    logic [TAG_W-1:0] tag_q [SETS];

    // Read ports: plain indexed lookup.
    assign ra_st  = st_q[ra_idx];
    assign ra_tag = tag_q[ra_idx];
    assign rb_st  = st_q[rb_idx];
    assign rb_tag = tag_q[rb_idx];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        // One set: snoop update first, then local update, reset to invalid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[s]  <= LN_INV;
                tag_q[s] <= '0;
            end else if (ws_en && (ws_idx == IDX_W'(s))) begin
                st_q[s] <= ws_st;
            end else if (wl_en && (wl_idx == IDX_W'(s))) begin
                st_q[s]  <= wl_st;
                tag_q[s] <= wl_tag;
            end
        end
    end

endmodule

// File: rtl/coh_snoop_unit.sv
// Reacts to another cache's bus transaction against the addressed set.
// Bus read on exclusive: flush and downgrade. Bus write on any valid
// copy: invalidate, flushing if dirty. Write-backs are ignored.
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             snp_valid,
    input  bus_cmd_t         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_t         ln_st,
    input  logic [TAG_W-1:0] ln_tag,
    output logic             flush,
    output logic             upd_en,
    output line_st_t         upd_st
);

    logic match;
    assign match = snp_valid && (ln_st != LN_INV) && (ln_tag == snp_tag);

    // Decide response and new state for the matching line.
    always_comb begin
        flush  = 1'b0;
        upd_en = 1'b0;
        upd_st = ln_st;
        if (match) begin
            unique case (snp_cmd)
                BUS_RD: begin
                    if (ln_st == LN_EXC) begin
                        flush  = 1'b1;
                        upd_en = 1'b1;
                        upd_st = LN_SHR;
                    end
                end
                BUS_INV: begin
                    flush  = (ln_st == LN_EXC);
                    upd_en = 1'b1;
                    upd_st = LN_INV;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/coh_req_fsm.sv
// Local request sequencer: decides hit, upgrade, fill or victim
// write-back, requests the bus and applies the granted transition.
// Any snoop to the request's set defers the decision or withdraws a
// pending bus request, which is then re-derived from the new state.
// Assumes cpu_valid/cpu_op/cpu_addr hold steady until cpu_done.
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    input  line_st_t          ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic              snp_valid,
    input  logic [IDX_W-1:0]  snp_idx,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    output logic              wl_en,
    output logic [IDX_W-1:0]  wl_idx,
    output line_st_t          wl_st,
    output logic [TAG_W-1:0]  wl_tag
);

    typedef enum logic [1:0] {F_IDLE, F_BUS, F_DONE} fsm_t;

    fsm_t              fsm_q, fsm_d;
    bus_cmd_t          cmd_q, cmd_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    logic [IDX_W-1:0] cpu_idx;
    logic [TAG_W-1:0] cpu_tag;
    logic             collide, hit, victim_dirty;

    assign cpu_idx      = cpu_addr[IDX_W-1:0];
    assign cpu_tag      = cpu_addr[ADDR_W-1:IDX_W];
    assign collide      = snp_valid && (snp_idx == cpu_idx);
    assign hit          = (ln_st != LN_INV) && (ln_tag == cpu_tag);
    assign victim_dirty = (ln_st == LN_EXC) && (ln_tag != cpu_tag);

    assign cpu_done = (fsm_q == F_DONE);
    assign bus_req  = (fsm_q == F_BUS);
    assign bus_cmd  = bus_req ? cmd_q : BUS_NONE;
    assign bus_addr = addr_q;

    // Next-state, pending transaction and local tag-array update.
    always_comb begin
        fsm_d  = fsm_q;
        cmd_d  = cmd_q;
        addr_d = addr_q;
        wl_en  = 1'b0;
        wl_idx = cpu_idx;
        wl_st  = LN_INV;
        wl_tag = cpu_tag;
        unique case (fsm_q)
            F_IDLE: begin
                if (cpu_valid && !collide) begin
                    unique case (cpu_op)
                        OP_RD: begin
                            if (hit) begin
                                fsm_d = F_DONE;
                            end else if (victim_dirty) begin
                                fsm_d  = F_BUS;
                                cmd_d  = BUS_WB;
                                addr_d = {ln_tag, cpu_idx};
                            end else begin
                                fsm_d  = F_BUS;
                                cmd_d  = BUS_RD;
                                addr_d = cpu_addr;
                            end
                        end
                        OP_WR: begin
                            if (hit && (ln_st == LN_EXC)) begin
                                fsm_d = F_DONE;
                            end else if (victim_dirty) begin
                                fsm_d  = F_BUS;
                                cmd_d  = BUS_WB;
                                addr_d = {ln_tag, cpu_idx};
                            end else begin
                                fsm_d  = F_BUS;
                                cmd_d  = BUS_INV;
                                addr_d = cpu_addr;
                            end
                        end
                        OP_EV: begin
                            if (hit && (ln_st == LN_EXC)) begin
                                fsm_d  = F_BUS;
                                cmd_d  = BUS_WB;
                                addr_d = cpu_addr;
                            end else begin
                                wl_en  = hit;
                                wl_tag = ln_tag;
                                fsm_d  = F_DONE;
                            end
                        end
                        default: fsm_d = F_DONE;
                    endcase
                end
            end
            F_BUS: begin
                if (bus_gnt) begin
                    wl_en  = 1'b1;
                    wl_idx = addr_q[IDX_W-1:0];
                    wl_tag = addr_q[ADDR_W-1:IDX_W];
                    unique case (cmd_q)
                        BUS_RD:  begin wl_st = LN_SHR; fsm_d = F_DONE; end
                        BUS_INV: begin wl_st = LN_EXC; fsm_d = F_DONE; end
                        default: begin wl_st = LN_INV; fsm_d = F_IDLE; end
                    endcase
                end else if (collide) begin
                    fsm_d = F_IDLE;
                end
            end
            default: fsm_d = F_IDLE;
        endcase
    end

    // State and pending-transaction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q  <= F_IDLE;
            cmd_q  <= BUS_NONE;
            addr_q <= '0;
        end else begin
            fsm_q  <= fsm_d;
            cmd_q  <= cmd_d;
            addr_q <= addr_d;
        end
    end

endmodule

// File: rtl/coh_snoop_ctrl.sv
// Top of the per-cache snooping write-invalidate controller.
// Joins the tag array, the snoop responder and the local sequencer.
// Assumes the bus never drives snp_valid and bus_gnt together and
// never presents this cache's own transactions on the snoop port.
module coh_snoop_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SETS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_t         ra_st, rb_st, ws_st, wl_st;
    logic [TAG_W-1:0] ra_tag, rb_tag, wl_tag;
    logic             ws_en, wl_en;
    logic [IDX_W-1:0] wl_idx, snp_idx;

    assign snp_idx = snp_addr[IDX_W-1:0];

    coh_tag_array #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (cpu_addr[IDX_W-1:0]),
        .ra_st  (ra_st),
        .ra_tag (ra_tag),
        .rb_idx (snp_idx),
        .rb_st  (rb_st),
        .rb_tag (rb_tag),
        .ws_en  (ws_en),
        .ws_idx (snp_idx),
        .ws_st  (ws_st),
        .wl_en  (wl_en),
        .wl_idx (wl_idx),
        .wl_st  (wl_st),
        .wl_tag (wl_tag)
    );

    coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_t'(snp_cmd)),
        .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
        .ln_st     (rb_st),
        .ln_tag    (rb_tag),
        .flush     (snp_flush),
        .upd_en    (ws_en),
        .upd_st    (ws_st)
    );

    coh_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_op    (cpu_op),
        .cpu_addr  (cpu_addr),
        .cpu_done  (cpu_done),
        .ln_st     (ra_st),
        .ln_tag    (ra_tag),
        .snp_valid (snp_valid),
        .snp_idx   (snp_idx),
        .bus_req   (bus_req),
        .bus_cmd   (bus_cmd),
        .bus_addr  (bus_addr),
        .bus_gnt   (bus_gnt),
        .wl_en     (wl_en),
        .wl_idx    (wl_idx),
        .wl_st     (wl_st),
        .wl_tag    (wl_tag)
    );

endmodule

// File: rtl/coh_snoop_ctrl_chk.sv
// Port-level temporal checks for coh_snoop_ctrl, attached by bind.
module coh_snoop_ctrl_chk #(
    parameter int ADDR_W = 12,
    parameter int SETS   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              bus_req,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_gnt,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_flush
);

    localparam int IDX_W = $clog2(SETS);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R2
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_cmd == 2'b01) |=> cpu_done);

    // R3
    upgrade_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_cmd == 2'b10) |=> cpu_done);

    // R6
    wb_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_cmd == 2'b11) |=> !cpu_done);

    // R7
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> (snp_valid && (snp_cmd == 2'b01 || snp_cmd == 2'b10)));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=>
            (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && snp_valid &&
         snp_addr[IDX_W-1:0] == bus_addr[IDX_W-1:0]) |=> !bus_req);

    // R9
    req_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != 2'b00 && !cpu_done));

endmodule

bind coh_snoop_ctrl coh_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .SETS(SETS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_done  (cpu_done),
    .bus_req   (bus_req),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .bus_gnt   (bus_gnt),
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_addr  (snp_addr),
    .snp_flush (snp_flush)
);

// File: tb/coh_snoop_ctrl_test.sv
`timescale 1ns/1ps
// Two controllers on one bus with a fixed-priority arbiter, a memory
// and per-cache data copies driven only by observed bus events.
module coh_snoop_ctrl_test;

    localparam int AW = 6;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          a_valid = 1'b0, b_valid = 1'b0;
    logic [1:0]    a_op = 2'b00, b_op = 2'b00;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic          a_done, b_done, a_req, b_req, a_flush, b_flush;
    logic [1:0]    a_cmd, b_cmd;
    logic [AW-1:0] a_baddr, b_baddr;
    logic          a_gnt, b_gnt;

    assign a_gnt = a_req;
    assign b_gnt = b_req && !a_req;

    coh_snoop_ctrl #(.ADDR_W(AW), .SETS(NS)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(a_valid), .cpu_op(a_op),
        .cpu_addr(a_addr), .cpu_done(a_done), .bus_req(a_req),
        .bus_cmd(a_cmd), .bus_addr(a_baddr), .bus_gnt(a_gnt),
        .snp_valid(b_gnt), .snp_cmd(b_cmd), .snp_addr(b_baddr),
        .snp_flush(a_flush)
    );

    coh_snoop_ctrl #(.ADDR_W(AW), .SETS(NS)) peer (
        .clk(clk), .rst_n(rst_n), .cpu_valid(b_valid), .cpu_op(b_op),
        .cpu_addr(b_addr), .cpu_done(b_done), .bus_req(b_req),
        .bus_cmd(b_cmd), .bus_addr(b_baddr), .bus_gnt(b_gnt),
        .snp_valid(a_gnt), .snp_cmd(a_cmd), .snp_addr(a_baddr),
        .snp_flush(b_flush)
    );

    logic [15:0] mem  [64];
    logic [15:0] refm [64];
    logic [15:0] cpy  [2][64];
    int          txn [2];
    int          fl  [2];
    int          wdr [2];
    logic [7:0]  seq [2];
    logic [1:0]  cur_op [2];
    logic [5:0]  cur_ad [2];
    logic [15:0] cur_wd [2];
    logic        prq [2];
    logic        pgn [2];
    int          lat;
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Completion of a request: apply write or check read value.
    task automatic fin(input int k);
        if (cur_op[k] == 2'b01) begin
            cpy[k][cur_ad[k]] = cur_wd[k];
            refm[cur_ad[k]]   = cur_wd[k];
        end else if (cur_op[k] == 2'b00) begin
            // R10: never stale
            chk(cpy[k][cur_ad[k]] == refm[cur_ad[k]], "R10 read value",
                int'(cpy[k][cur_ad[k]]), int'(refm[cur_ad[k]]));
        end
    endtask

    // A granted bus transaction and the peer's flush in the same cycle.
    task automatic bus_evt(input int k, input logic [1:0] cmd,
                           input logic [5:0] ad, input logic ofl);
        txn[k]++;
        seq[k] = {seq[k][5:0], cmd};
        if (ofl) mem[ad] = cpy[1-k][ad];
        if (cmd == 2'b01) cpy[k][ad] = mem[ad];
        if (cmd == 2'b11) mem[ad] = cpy[k][ad];
    endtask

    // Bus and completion monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (a_done) fin(0);
            if (b_done) fin(1);
            if (a_gnt) bus_evt(0, a_cmd, a_baddr, b_flush);
            if (b_gnt) bus_evt(1, b_cmd, b_baddr, a_flush);
            if (prq[0] && !pgn[0] && !a_req) wdr[0]++;
            if (prq[1] && !pgn[1] && !b_req) wdr[1]++;
            if (a_flush) fl[0]++;
            if (b_flush) fl[1]++;
            prq[0] = a_req; pgn[0] = a_gnt;
            prq[1] = b_req; pgn[1] = b_gnt;
        end
    end

    // Issue one request at a negedge, hold it until completion.
    task automatic do_op(input int k, input logic [1:0] op,
                         input logic [5:0] ad, input logic [15:0] wd);
        int n;
        @(negedge clk);
        cur_op[k] = op; cur_ad[k] = ad; cur_wd[k] = wd;
        if (k == 0) begin a_op = op; a_addr = ad; a_valid = 1'b1; end
        else        begin b_op = op; b_addr = ad; b_valid = 1'b1; end
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!((k == 0) ? a_done : b_done));
        lat = n;
        if (k == 0) a_valid = 1'b0; else b_valid = 1'b0;
    endtask

    task automatic rnd_run(input int k, input int n);
        for (int i = 0; i < n; i++) begin
            int          r;
            logic [1:0]  op;
            logic [5:0]  ad;
            r  = int'($urandom % 10);
            op = (r < 5) ? 2'b00 : ((r < 9) ? 2'b01 : 2'b10);
            ad = 6'((($urandom % 3) + 1) * 4 + ($urandom % 2));
            do_op(k, op, ad, 16'($urandom));
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [5:0] AX = 6'h05;
    localparam logic [5:0] AY = 6'h09;

    initial begin
        int t0, t1, f0, w1;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            mem[i] = '0; refm[i] = '0; cpy[0][i] = '0; cpy[1][i] = '0;
        end
        for (int k = 0; k < 2; k++) begin
            txn[k] = 0; fl[k] = 0; wdr[k] = 0; seq[k] = '0;
            prq[k] = 1'b0; pgn[k] = 1'b0;
            cur_op[k] = 2'b11; cur_ad[k] = '0; cur_wd[k] = '0;
        end
        repeat (4) @(negedge clk);
        // R1: quiet outputs during reset
        chk(!a_done && !b_done, "R1 reset done", int'(a_done | b_done), 0);
        chk(!a_req && !b_req, "R1 reset bus_req", int'(a_req | b_req), 0);
        chk(!a_flush && !b_flush, "R1 reset flush", int'(a_flush | b_flush), 0);
        rst_n = 1'b1;

        // R1 R2: first read misses with a bus read
        t0 = txn[0];
        do_op(0, 2'b00, AX, 16'h0);
        chk(txn[0] - t0 == 1 && seq[0][1:0] == 2'b01, "R1 first read bus read", txn[0] - t0, 1);
        // R2: read hit, no bus, done next cycle
        t0 = txn[0];
        do_op(0, 2'b00, AX, 16'h0);
        chk(txn[0] - t0 == 0, "R2 read hit no bus", txn[0] - t0, 0);
        chk(lat == 1, "R2 read hit latency", lat, 1);
        // R7: shared holder does not flush on a remote read
        t1 = txn[1]; f0 = fl[0];
        do_op(1, 2'b00, AX, 16'h0);
        chk(txn[1] - t1 == 1 && seq[1][1:0] == 2'b01, "R2 peer read fill", txn[1] - t1, 1);
        chk(fl[0] == f0, "R7 shared no flush", fl[0] - f0, 0);
        // R3: write to shared issues bus write
        t0 = txn[0];
        do_op(0, 2'b01, AX, 16'h1111);
        chk(txn[0] - t0 == 1 && seq[0][1:0] == 2'b10, "R3 upgrade bus write", int'(seq[0][1:0]), 2);
        // R5: remote read of exclusive line flushes
        t1 = txn[1]; f0 = fl[0];
        do_op(1, 2'b00, AX, 16'h0);
        chk(txn[1] - t1 == 1, "R3 invalidated peer misses", txn[1] - t1, 1);
        chk(fl[0] - f0 == 1, "R5 flush on remote read", fl[0] - f0, 1);
        // R5: downgraded to shared, so write needs bus write again
        t0 = txn[0];
        do_op(0, 2'b01, AX, 16'h2222);
        chk(txn[0] - t0 == 1 && seq[0][1:0] == 2'b10, "R5 downgrade to shared", txn[0] - t0, 1);
        // R4: write hit on exclusive stays local
        t0 = txn[0];
        do_op(0, 2'b01, AX, 16'h3333);
        chk(txn[0] - t0 == 0, "R4 write hit no bus", txn[0] - t0, 0);
        chk(lat == 1, "R4 write hit latency", lat, 1);
        // R6: conflicting read writes back dirty victim then fills
        t0 = txn[0];
        do_op(0, 2'b00, AY, 16'h0);
        chk(txn[0] - t0 == 2 && seq[0][3:0] == 4'b1101, "R6 victim write-back then fill",
            int'(seq[0][3:0]), 13);
        chk(mem[AX] == refm[AX], "R6 memory after write-back", int'(mem[AX]), int'(refm[AX]));
        // R6: evicting shared line is silent
        t0 = txn[0];
        do_op(0, 2'b10, AY, 16'h0);
        chk(txn[0] - t0 == 0, "R6 silent shared evict", txn[0] - t0, 0);
        // R6: evicting exclusive line writes back
        do_op(0, 2'b01, AX, 16'h4444);
        t0 = txn[0];
        do_op(0, 2'b10, AX, 16'h0);
        chk(txn[0] - t0 == 1 && seq[0][1:0] == 2'b11, "R6 exclusive evict write-back", int'(seq[0][1:0]), 3);
        // R3: peer copy was invalidated by the earlier bus write
        t1 = txn[1];
        do_op(1, 2'b00, AX, 16'h0);
        chk(txn[1] - t1 == 1 && seq[1][1:0] == 2'b01, "R3 peer refetch", txn[1] - t1, 1);
        // R8: same-cycle contention, loser withdraws and retries
        w1 = wdr[1]; t0 = txn[0]; t1 = txn[1];
        fork
            do_op(0, 2'b01, AX, 16'h5555);
            do_op(1, 2'b01, AX, 16'h6666);
        join
        chk(wdr[1] - w1 == 1, "R8 loser withdraws", wdr[1] - w1, 1);
        chk(txn[0] - t0 == 1 && txn[1] - t1 == 1, "R8 one bus write each",
            txn[0] - t0 + txn[1] - t1, 2);
        // R10: both read the serialized final value
        do_op(0, 2'b00, AX, 16'h0);
        do_op(1, 2'b00, AX, 16'h0);
        chk(refm[AX] == 16'h6666, "R10 write order", int'(refm[AX]), 16'h6666);

        // R10: random mixed traffic from both processors
        fork
            rnd_run(0, 1500);
            rnd_run(1, 1500);
        join

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule